// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block gathers message-signalled interrupts that arrive as writes to one doorbell address and folds them into a single level-high interrupt line for a system interrupt controller. Each doorbell write carries a data word that names a vector. The block records that vector as a pending bit in a bank of 32-bit status words. The output line stays high while any pending vector is also enabled.

Software reaches the block through a small register port with a combinational read path and a one-cycle write strobe. It reads the pending words and clears bits by writing ones to them. It also reads and rewrites the per-vector enable words. Every message is an edge-type event, so repeated messages for a vector that is already pending merge into one bit. When a new message and a software clear hit the same bit in the same cycle, the message is kept.

Top module: `msi_irq_agg`

## Requirements
- R1: A doorbell write (`dbValid` high, `dbAddr` equal to `DOORBELL_ADDR`) with data n below `NUM_VEC` sets pending bit n, which is bit n mod 32 of status word n/32. The bit is visible on the following cycle.
- R2: A doorbell write to any other address changes no pending bit.
- R3: A doorbell write whose data is `NUM_VEC` (128) or more changes no pending bit.
- R4: A register read at byte offset 4·k returns status word k, for k from 0 to 3 (0x00–0x0C). A read at 0x10 + 4·k returns enable word k (0x10–0x1C). Reads show the current contents.
- R5: A register write to a status word clears each pending bit whose written bit is 1. Bits written as 0 keep their value.
- R6: A register write to an enable word replaces all 32 bits of that word.
- R7: `irqOut` is high exactly when some vector has both its pending bit and its enable bit set. It follows a set, a clear or an enable change on the cycle after that write.
- R8: Several messages for the same vector leave one pending bit, and a single clear removes it.
- R9: When a doorbell set and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: A synchronous reset clears every pending and enable bit and drives `irqOut` low.
- R11: Offsets at 0x20 and above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbValid | input | 1 | Inbound message write is present this cycle |
| dbAddr | input | ADDR_W (32) | Target address of the inbound write |
| dbData | input | 32 | Data word of the inbound write, the vector number |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_ADDR_W (8) | Register byte offset for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irqOut | output | 1 | Level interrupt towards the system controller |

## Verification
The hardest case to reach is a message and a software clear that meet on the same bit in the same cycle. In normal use the clear comes long after the set. The bench drives the doorbell and the register write together on one clock edge, both for the same vector and for different vectors in the same word, and checks that only the intended bits survive. It also sends every one of the 128 vectors with all enables set, reads back all eight words after each message, and clears each vector with a written zero and then a written one. This shows that a message lands in exactly one bit and that only a 1 clears it.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_MAXW = 16;
  localparam int SEL_MAXW = 8;

  typedef struct packed {
    logic                setEn;
    logic [IDX_MAXW-1:0] setIdx;
    logic                clrEn;
    logic                enWrEn;
    logic [SEL_MAXW-1:0] wrWord;
    logic [WORD_W-1:0]   wrData;
    logic                rdValid;
    logic                rdEnBank;
    logic [SEL_MAXW-1:0] rdWord;
  } ctlStrobes_t;
endpackage

// File: rtl/msi_agg_ctrl.sv
module msi_agg_ctrl
  import msi_agg_pkg::*;
#(
  parameter int          NUM_VEC       = 128,
  parameter int          ADDR_W        = 32,
  parameter int          REG_ADDR_W    = 8,
  parameter logic [31:0] DOORBELL_ADDR = 32'h0000_1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dbValid,
  input  logic [ADDR_W-1:0]     dbAddr,
  input  logic [WORD_W-1:0]     dbData,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWrData,
  output ctlStrobes_t           ctl
);
  localparam int WORDS    = NUM_VEC / WORD_W;
  localparam int SEL_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BANK_BIT = 2 + SEL_W;

  logic dbHit, vecOk, mapped, bankSel;
  logic [SEL_W-1:0] wordSel;

  assign dbHit   = dbValid && (dbAddr == DOORBELL_ADDR[ADDR_W-1:0]);
  assign vecOk   = (dbData < WORD_W'(NUM_VEC));
  assign mapped  = (regAddr >> (BANK_BIT + 1)) == '0;
  assign bankSel = regAddr[BANK_BIT];
  assign wordSel = regAddr[2 +: SEL_W];

  always_comb begin
    ctl          = '0;
    ctl.setEn    = dbHit && vecOk;
    ctl.setIdx   = IDX_MAXW'(dbData);
    ctl.clrEn    = regWrEn && mapped && !bankSel;
    ctl.enWrEn   = regWrEn && mapped && bankSel;
    ctl.wrWord   = SEL_MAXW'(wordSel);
    ctl.wrData   = regWrData;
    ctl.rdValid  = mapped;
    ctl.rdEnBank = bankSel;
    ctl.rdWord   = SEL_MAXW'(wordSel);
  end

  // R3
  no_bad_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (dbValid && dbData >= WORD_W'(NUM_VEC)) |-> !ctl.setEn);

  // R11
  no_unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr >= REG_ADDR_W'(2 * WORDS * 4)) |-> !(ctl.clrEn || ctl.enWrEn));
endmodule

// File: rtl/msi_agg_dp.sv
module msi_agg_dp
  import msi_agg_pkg::*;
#(
  parameter int NUM_VEC = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);
  localparam int WORDS = NUM_VEC / WORD_W;
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int POS_W = $clog2(WORD_W);

  logic [WORD_W-1:0]  statusW [WORDS];
  logic [WORD_W-1:0]  enableW [WORDS];
  logic [WORDS-1:0]   activeW;
  logic [NUM_VEC-1:0] statusFlat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] stQ, enQ, setMask, clrMask;

    always_comb begin
      setMask = '0;
      if (ctl.setEn && (int'(ctl.setIdx >> POS_W) == w))
        setMask[ctl.setIdx[POS_W-1:0]] = 1'b1;
      clrMask = (ctl.clrEn && int'(ctl.wrWord) == w) ? ctl.wrData : '0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stQ <= '0;
        enQ <= '0;
      end else begin
        stQ <= (stQ & ~clrMask) | setMask;
        if (ctl.enWrEn && int'(ctl.wrWord) == w)
          enQ <= ctl.wrData;
      end
    end

    assign statusW[w]                    = stQ;
    assign enableW[w]                    = enQ;
    assign activeW[w]                    = |(stQ & enQ);
    assign statusFlat[w*WORD_W +: WORD_W] = stQ;
  end

  assign irqOut = |activeW;

  always_comb begin
    rdData = '0;
    if (ctl.rdValid)
      rdData = ctl.rdEnBank ? enableW[ctl.rdWord[SEL_W-1:0]]
                            : statusW[ctl.rdWord[SEL_W-1:0]];
  end

  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.setEn |=> statusFlat[$past(ctl.setIdx[$clog2(NUM_VEC)-1:0])]);

  // R8
  one_new_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(statusFlat & ~$past(statusFlat)));

  // R7
  irq_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (irqOut && !ctl.clrEn && !ctl.enWrEn) |=> irqOut);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (statusFlat == '0 && !irqOut));
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
  import msi_agg_pkg::*;
#(
  parameter int          NUM_VEC       = 128,
  parameter int          ADDR_W        = 32,
  parameter int          REG_ADDR_W    = 8,
  parameter logic [31:0] DOORBELL_ADDR = 32'h0000_1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dbValid,
  input  logic [ADDR_W-1:0]     dbAddr,
  input  logic [31:0]           dbData,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  output logic                  irqOut
);
  ctlStrobes_t ctl;

  msi_agg_ctrl #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .REG_ADDR_W(REG_ADDR_W),
    .DOORBELL_ADDR(DOORBELL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .dbValid(dbValid), .dbAddr(dbAddr), .dbData(dbData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .ctl(ctl)
  );

  msi_agg_dp #(.NUM_VEC(NUM_VEC)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/msi_irq_agg_test.sv
module msi_irq_agg_test;
  localparam logic [31:0] DB = 32'h0000_1000;

  logic        clk = 0, rst = 1;
  logic        dbValid = 0, regWrEn = 0;
  logic [31:0] dbAddr = 0, dbData = 0, regWrData = 0, regRdData;
  logic [7:0]  regAddr = 0;
  logic        irqOut;
  int          nChecks = 0, nFails = 0;
  logic [31:0] expSt [4];
  logic [31:0] expEn [4];

  always #5 clk = ~clk;

  msi_irq_agg uut (
    .clk(clk), .rst(rst), .dbValid(dbValid), .dbAddr(dbAddr), .dbData(dbData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic checkAll(string req);
    logic [31:0] v;
    logic        anyAct = 0;
    for (int k = 0; k < 4; k++) begin
      rd(8'(4 * k), v);        chk({req, " status"}, v, expSt[k]);
      rd(8'(16 + 4 * k), v);   chk({req, " enable"}, v, expEn[k]);
      anyAct |= |(expSt[k] & expEn[k]);
    end
    chk({req, " irq"}, 32'(irqOut), 32'(anyAct));
  endtask

  task automatic bell(input logic [31:0] a, input logic [31:0] d);
    dbValid = 1; dbAddr = a; dbData = d; tick(); dbValid = 0;
    if (a == DB && d < 128) expSt[d / 32][d % 32] = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; tick(); regWrEn = 0;
    if (a < 8'h10 && a[1:0] == 0) expSt[a[3:2]] &= ~d;
    else if (a < 8'h20 && a[1:0] == 0) expEn[a[3:2]] = d;
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        nFails++; nChecks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    join_none

    for (int k = 0; k < 4; k++) begin expSt[k] = 0; expEn[k] = 0; end
    repeat (3) tick();
    rst = 0; tick();
    checkAll("R10 reset");

    for (int k = 0; k < 4; k++) wr(8'(16 + 4 * k), 32'hFFFF_FFFF);
    checkAll("R6 enable all");

    // R1 R4 R5 R7: every vector, in each word
    for (int n = 0; n < 128; n++) begin
      bell(DB, n);
      checkAll("R1 set");
      wr(8'(4 * (n / 32)), 32'h0);
      checkAll("R5 write zero keeps");
      wr(8'(4 * (n / 32)), 32'h1 << (n % 32));
      checkAll("R5 clear");
    end

    // R2: wrong address, R3: vector out of range
    bell(DB + 4, 3);   checkAll("R2 other address");
    bell(32'h0, 3);    checkAll("R2 other address");
    for (int d = 128; d < 140; d++) begin bell(DB, d); checkAll("R3 out of range"); end
    bell(DB, 32'hFFFF_FFFF); checkAll("R3 out of range");

    // R8: repeated messages collapse
    bell(DB, 70); bell(DB, 70); bell(DB, 70);
    checkAll("R8 collapse");
    wr(8'h08, 32'h1 << 6);
    checkAll("R8 single clear");

    // R9: set and clear of same bit together; different bit in same word
    bell(DB, 40);
    dbValid = 1; dbAddr = DB; dbData = 40;
    regWrEn = 1; regAddr = 8'h04; regWrData = 32'h0000_0100; tick();
    dbValid = 0; regWrEn = 0;
    checkAll("R9 set wins");
    bell(DB, 41);
    dbValid = 1; dbAddr = DB; dbData = 42;
    regWrEn = 1; regAddr = 8'h04; regWrData = 32'h0000_0200; tick();
    dbValid = 0; regWrEn = 0;
    expSt[1] = 32'h0000_0500;
    checkAll("R9 mixed");
    wr(8'h04, 32'hFFFF_FFFF);

    // R7: enable gating
    bell(DB, 5);
    wr(8'h10, 32'h0);          checkAll("R7 disabled");
    wr(8'h10, 32'h0000_0020);  checkAll("R7 enabled one");
    wr(8'h10, 32'h0000_0010);  checkAll("R7 other enabled");
    wr(8'h1C, 32'hA5A5_0F0F);  checkAll("R6 replace");

    // R11: unmapped offsets
    begin
      logic [31:0] v;
      wr(8'h20, 32'hFFFF_FFFF);  checkAll("R11 write ignored");
      wr(8'hF0, 32'hFFFF_FFFF);  checkAll("R11 write ignored");
      rd(8'h20, v); chk("R11 read zero", v, 32'h0);
      rd(8'h84, v); chk("R11 read zero", v, 32'h0);
    end

    // R10: reset with live state
    bell(DB, 100); wr(8'h1C, 32'hFFFF_FFFF);
    checkAll("R7 before reset");
    rst = 1; tick(); rst = 0;
    for (int k = 0; k < 4; k++) begin expSt[k] = 0; expEn[k] = 0; end
    checkAll("R10 reset live");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule